// File: doc/BRIEF.md
# Branch Resolution Unit

This block decides where control flow goes next for a compact 16-bit instruction encoding. Each cycle it may take one decoded branch request. The request carries a branch kind, a 4-bit condition code, an 11-bit offset field, the current PC, a register operand, the current link value and the four arithmetic flags. One clock later the block returns a registered result: whether the branch is taken, the target address, an optional write to the link register, a request to clear the processor state bit, and an undefined-encoding indication.

Five branch kinds are handled:

- **Conditional short branch.** Tested against the flags, with an 8-bit signed displacement.
- **Unconditional branch.** Uses an 11-bit signed displacement.
- **Long call, first half.** Parks a partial target in the link register.
- **Long call, second half.** Jumps through the link register and replaces it with an odd return address.
- **Register-indirect branch.** Leaves the alternate instruction state when the register holds an even address.

Instruction fetch and the register file sit outside. The surrounding pipeline writes `lr_data_o` back to its link register when `lr_we_o` is high. It flushes and redirects fetch on `taken_o`.

Top module: `branch_resolve_unit`

## Requirements
- R1: For kind 0 (conditional), codes 0..7 test one flag each: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear. Flags arrive as `flags_i` = {N, Z, C, V} (bit 3 is N, bit 0 is V).
- R2: Conditional code 8 is taken when C is set and Z is clear. Code 9 is taken when C is clear or Z is set.
- R3: Conditional code 10 is taken when N equals V, and code 11 when N differs from V. Code 12 is taken when Z is clear and N equals V. Code 13 is taken when Z is set or N differs from V.
- R4: Conditional codes 14 and 15, and the kind values 5, 6 and 7, are not branches. The result has `undef_o` high, `taken_o` low, no link write, no state clear, and `target_o` zero.
- R5: A conditional branch presents `target_o` = PC + 4 + 2 × sign-extended `offset_i[7:0]` whether or not it is taken. `offset_i[10:8]` has no effect on it.
- R6: Kind 1 (unconditional) is always taken, with `target_o` = PC + 4 + 2 × sign-extended `offset_i[10:0]`, and no link write.
- R7: Kind 2 (long call, first half) is not taken and has `target_o` zero. It writes the link register with PC + 4 + (sign-extended `offset_i[10:0]` shifted left by 12).
- R8: Kind 3 (long call, second half) is taken with `target_o` = `lr_i` + 2 × zero-extended `offset_i[10:0]`. It writes the link register with (PC + 2) OR 1.
- R9: Kind 4 (register-indirect) is taken with `target_o` = `reg_val_i` with bit 0 cleared. `state_clr_o` is high exactly when bit 0 of `reg_val_i` is 0. There is no link write.
- R10: Each result appears on the outputs one clock after the request, with `out_valid_o` high. A cycle without `in_valid_i` yields `out_valid_o` low and all strobes and data low. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A branch request is present this cycle |
| kind_i | input | 3 | Branch kind: 0 conditional, 1 unconditional, 2 call first half, 3 call second half, 4 indirect |
| cond_i | input | 4 | Condition code for the conditional kind |
| offset_i | input | 11 | Offset field; the short conditional form uses bits 7:0 |
| pc_i | input | 32 | Address of the branch instruction |
| reg_val_i | input | 32 | Register operand for the indirect kind |
| lr_i | input | 32 | Current link register value |
| flags_i | input | 4 | Flags {N, Z, C, V} |
| out_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Control flow redirects to target_o |
| target_o | output | 32 | Next-PC target |
| undef_o | output | 1 | Request was not a branch encoding |
| lr_we_o | output | 1 | Write lr_data_o into the link register |
| lr_data_o | output | 32 | Link register write value |
| state_clr_o | output | 1 | Clear the instruction-state bit |

## Verification
The bench sweeps every condition code against all sixteen flag combinations. An evaluator that swapped the carry sense of codes 8/9, or mixed up the N/V comparison in codes 12/13, would send signed and unsigned compares the wrong way. The bench uses negative displacements and the most negative 11-bit value. A target calculation that zero-extended, or forgot the +4 prefetch bias, would land at the wrong address. Call first halves with a negative high field, an all-ones low field, and even or odd indirect registers are aimed at sign-extension slips, a return address missing its low bit, or a state clear raised on the wrong parity.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;

    typedef enum logic [2:0] {
        BK_COND     = 3'd0,
        BK_JUMP     = 3'd1,
        BK_CALL_HI  = 3'd2,
        BK_CALL_LO  = 3'd3,
        BK_INDIRECT = 3'd4
    } br_kind_e;

    // Bit positions inside the flags vector
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

endpackage

// File: rtl/bru_cond_eval.sv
`timescale 1ns/1ps
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [COND_W-1:0] code_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              hit_o,
    output logic              legal_o
);

    logic n, z, c, v;
    logic sgn_eq;

    assign n      = flags_i[FLAG_N];
    assign z      = flags_i[FLAG_Z];
    assign c      = flags_i[FLAG_C];
    assign v      = flags_i[FLAG_V];
    assign sgn_eq = (n == v);

    always_comb begin
        legal_o = 1'b1;
        hit_o   = 1'b0;
        case (code_i)
            4'h0: hit_o = z;
            4'h1: hit_o = !z;
            4'h2: hit_o = c;
            4'h3: hit_o = !c;
            4'h4: hit_o = n;
            4'h5: hit_o = !n;
            4'h6: hit_o = v;
            4'h7: hit_o = !v;
            4'h8: hit_o = c && !z;
            4'h9: hit_o = !c || z;
            4'hA: hit_o = sgn_eq;
            4'hB: hit_o = !sgn_eq;
            4'hC: hit_o = !z && sgn_eq;
            4'hD: hit_o = z || !sgn_eq;
            default: begin
                hit_o   = 1'b0;
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bru_target_calc.sv
`timescale 1ns/1ps
module bru_target_calc #(
    parameter int XLEN    = 32,
    parameter int LONG_W  = 11,
    parameter int SHORT_W = 8
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [LONG_W-1:0] offset_i,
    input  logic [XLEN-1:0]   lr_i,
    output logic [XLEN-1:0]   short_tgt_o,
    output logic [XLEN-1:0]   jump_tgt_o,
    output logic [XLEN-1:0]   hi_link_o,
    output logic [XLEN-1:0]   lo_tgt_o,
    output logic [XLEN-1:0]   ret_link_o
);

    localparam int SPAD     = XLEN - SHORT_W;
    localparam int LPAD     = XLEN - LONG_W;
    localparam int HI_SHIFT = LONG_W + 1;

    logic [XLEN-1:0] pc_ahead;
    logic [XLEN-1:0] short_sx;
    logic [XLEN-1:0] long_sx;
    logic [XLEN-1:0] long_zx;

    assign pc_ahead = pc_i + XLEN'(4);
    assign short_sx = {{SPAD{offset_i[SHORT_W-1]}}, offset_i[SHORT_W-1:0]};
    assign long_sx  = {{LPAD{offset_i[LONG_W-1]}}, offset_i};
    assign long_zx  = {{LPAD{1'b0}}, offset_i};

    assign short_tgt_o = pc_ahead + (short_sx << 1);
    assign jump_tgt_o  = pc_ahead + (long_sx << 1);
    assign hi_link_o   = pc_ahead + (long_sx << HI_SHIFT);
    assign lo_tgt_o    = lr_i + (long_zx << 1);
    assign ret_link_o  = (pc_i + XLEN'(2)) | XLEN'(1);

endmodule

// File: rtl/branch_resolve_unit.sv
`timescale 1ns/1ps
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int LONG_W  = 11,
    parameter int SHORT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [2:0]        kind_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [LONG_W-1:0] offset_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   reg_val_i,
    input  logic [XLEN-1:0]   lr_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              out_valid_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   target_o,
    output logic              undef_o,
    output logic              lr_we_o,
    output logic [XLEN-1:0]   lr_data_o,
    output logic              state_clr_o
);

    typedef struct packed {
        logic            valid;
        logic            taken;
        logic            undef;
        logic            lr_we;
        logic            state_clr;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] lr_data;
    } res_t;

    res_t res_d, res_q;

    logic            cond_hit;
    logic            cond_legal;
    logic [XLEN-1:0] short_tgt;
    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] hi_link;
    logic [XLEN-1:0] lo_tgt;
    logic [XLEN-1:0] ret_link;

    bru_cond_eval u_cond (
        .code_i  (cond_i),
        .flags_i (flags_i),
        .hit_o   (cond_hit),
        .legal_o (cond_legal)
    );

    bru_target_calc #(
        .XLEN    (XLEN),
        .LONG_W  (LONG_W),
        .SHORT_W (SHORT_W)
    ) u_tgt (
        .pc_i        (pc_i),
        .offset_i    (offset_i),
        .lr_i        (lr_i),
        .short_tgt_o (short_tgt),
        .jump_tgt_o  (jump_tgt),
        .hi_link_o   (hi_link),
        .lo_tgt_o    (lo_tgt),
        .ret_link_o  (ret_link)
    );

    always_comb begin
        res_d = '0;
        if (in_valid_i) begin
            res_d.valid = 1'b1;
            case (kind_i)
                BK_COND: begin
                    if (cond_legal) begin
                        res_d.taken  = cond_hit;
                        res_d.target = short_tgt;
                    end else begin
                        res_d.undef  = 1'b1;
                    end
                end
                BK_JUMP: begin
                    res_d.taken  = 1'b1;
                    res_d.target = jump_tgt;
                end
                BK_CALL_HI: begin
                    res_d.lr_we   = 1'b1;
                    res_d.lr_data = hi_link;
                end
                BK_CALL_LO: begin
                    res_d.taken   = 1'b1;
                    res_d.target  = lo_tgt;
                    res_d.lr_we   = 1'b1;
                    res_d.lr_data = ret_link;
                end
                BK_INDIRECT: begin
                    res_d.taken     = 1'b1;
                    res_d.target    = {reg_val_i[XLEN-1:1], 1'b0};
                    res_d.state_clr = !reg_val_i[0];
                end
                default: begin
                    res_d.undef = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid_o = res_q.valid;
    assign taken_o     = res_q.taken;
    assign target_o    = res_q.target;
    assign undef_o     = res_q.undef;
    assign lr_we_o     = res_q.lr_we;
    assign lr_data_o   = res_q.lr_data;
    assign state_clr_o = res_q.state_clr;

endmodule

// File: rtl/bru_checker.sv
`timescale 1ns/1ps
module bru_checker
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              in_valid_i,
    input logic [2:0]        kind_i,
    input logic [COND_W-1:0] cond_i,
    input logic [XLEN-1:0]   reg_val_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic              out_valid_o,
    input logic              taken_o,
    input logic [XLEN-1:0]   target_o,
    input logic              undef_o,
    input logic              lr_we_o,
    input logic [XLEN-1:0]   lr_data_o,
    input logic              state_clr_o
);

    logic is_cond;
    assign is_cond = in_valid_i && (kind_i == BK_COND);

    AST_ZERO_FLAG_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_cond && cond_i == 4'h0 |=> taken_o == $past(flags_i[FLAG_Z])); // R1

    AST_UNSIGNED_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_cond && cond_i == 4'h8 |=> taken_o == ($past(flags_i[FLAG_C]) && !$past(flags_i[FLAG_Z]))); // R2

    AST_SIGNED_GE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_cond && cond_i == 4'hA |=> taken_o == ($past(flags_i[FLAG_N]) == $past(flags_i[FLAG_V]))); // R3

    AST_NOT_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_cond && cond_i[3:1] == 3'b111 |=> undef_o && !taken_o && !lr_we_o && !state_clr_o); // R4

    AST_JUMP_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && kind_i == BK_JUMP |=> taken_o && !lr_we_o && !undef_o); // R6

    AST_CALL_HI_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && kind_i == BK_CALL_HI |=> lr_we_o && !taken_o); // R7

    AST_RETURN_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && kind_i == BK_CALL_LO |=> lr_we_o && lr_data_o[0] && taken_o); // R8

    AST_STATE_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && kind_i == BK_INDIRECT |=> taken_o && !target_o[0] && (state_clr_o == !$past(reg_val_i[0]))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o && !taken_o && !lr_we_o && !state_clr_o && !undef_o); // R10

    AST_REQ_GIVES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o); // R10

endmodule

bind branch_resolve_unit bru_checker #(.XLEN(XLEN)) u_bru_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .kind_i      (kind_i),
    .cond_i      (cond_i),
    .reg_val_i   (reg_val_i),
    .flags_i     (flags_i),
    .out_valid_o (out_valid_o),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .undef_o     (undef_o),
    .lr_we_o     (lr_we_o),
    .lr_data_o   (lr_data_o),
    .state_clr_o (state_clr_o)
);

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  kind = '0;
    logic [3:0]  cond = '0;
    logic [10:0] offset = '0;
    logic [31:0] pc = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] lr = '0;
    logic [3:0]  flags = '0;
    logic        out_valid, taken, undef, lr_we, state_clr;
    logic [31:0] target, lr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic        taken;
        logic        undef;
        logic        lr_we;
        logic        state_clr;
        logic [31:0] target;
        logic [31:0] lr_data;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    branch_resolve_unit uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .kind_i      (kind),
        .cond_i      (cond),
        .offset_i    (offset),
        .pc_i        (pc),
        .reg_val_i   (reg_val),
        .lr_i        (lr),
        .flags_i     (flags),
        .out_valid_o (out_valid),
        .taken_o     (taken),
        .target_o    (target),
        .undef_o     (undef),
        .lr_we_o     (lr_we),
        .lr_data_o   (lr_data),
        .state_clr_o (state_clr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one request and push the independently modelled result
    task automatic drive(input logic [2:0] k, input logic [3:0] cc, input logic [10:0] off,
                         input logic [31:0] p, input logic [31:0] rv, input logic [31:0] l,
                         input logic [3:0] fl, input string tag);
        exp_t e;
        logic fn, fz, fc, fv, base;
        int s8, s11;
        fn = fl[3]; fz = fl[2]; fc = fl[1]; fv = fl[0];
        s8  = off[7]  ? int'(off[7:0]) - 256 : int'(off[7:0]);
        s11 = off[10] ? int'(off) - 2048     : int'(off);
        e.taken = 0; e.undef = 0; e.lr_we = 0; e.state_clr = 0;
        e.target = '0; e.lr_data = '0; e.tag = tag;
        case (k)
            3'd0: begin
                base = 1'b0;
                case (cc[3:1])
                    3'd0: base = fz;
                    3'd1: base = fc;
                    3'd2: base = fn;
                    3'd3: base = fv;
                    3'd4: base = fc & ~fz;
                    3'd5: base = (fn == fv);
                    3'd6: base = ~fz & (fn == fv);
                    default: base = 1'b0;
                endcase
                if (cc[3:1] == 3'd7) e.undef = 1;
                else begin
                    e.taken  = base ^ cc[0];
                    e.target = p + 32'd4 + 32'(s8 * 2);
                end
            end
            3'd1: begin e.taken = 1; e.target = p + 32'd4 + 32'(s11 * 2); end
            3'd2: begin e.lr_we = 1; e.lr_data = p + 32'd4 + 32'(s11 * 4096); end
            3'd3: begin
                e.taken = 1; e.target = l + 32'(int'(off) * 2);
                e.lr_we = 1; e.lr_data = (p + 32'd2) | 32'd1;
            end
            3'd4: begin e.taken = 1; e.target = rv & ~32'd1; e.state_clr = ~rv[0]; end
            default: e.undef = 1;
        endcase
        @(negedge clk);
        in_valid = 1'b1; kind = k; cond = cc; offset = off;
        pc = p; reg_val = rv; lr = l; flags = fl;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        kind = 3'd1; offset = 11'h155; reg_val = 32'h0; pc = 32'h1234;
    endtask

    // Monitor: compare each produced result with the head of the scoreboard
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "result without request", 32'(out_valid), 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(taken == e.taken && undef == e.undef && lr_we == e.lr_we &&
                          state_clr == e.state_clr, e.tag, "strobes {taken,undef,lr_we,clr}",
                          {28'd0, taken, undef, lr_we, state_clr},
                          {28'd0, e.taken, e.undef, e.lr_we, e.state_clr});
                    check(target == e.target, e.tag, "target", target, e.target);
                    check(lr_data == e.lr_data, e.tag, "lr_data", lr_data, e.lr_data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        string tg;
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && !taken && !lr_we && !state_clr && !undef && target == 0 && lr_data == 0,
              "R10", "reset state", {27'd0, out_valid, taken, lr_we, state_clr, undef}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Condition sweep: every code against every flag pattern (R1, R2, R3, R4, R5)
        for (int cc = 0; cc < 16; cc++) begin
            for (int fl = 0; fl < 16; fl++) begin
                if (cc < 8)       tg = "R1";
                else if (cc < 10) tg = "R2";
                else if (cc < 14) tg = "R3";
                else              tg = "R4";
                drive(3'd0, 4'(cc), 11'(fl * 37 + 5), 32'h0000_1000 + 32'(cc * 64),
                      32'h0, 32'h0, 4'(fl), tg);
            end
        end

        // R5: negative displacement, upper offset bits ignored, address wrap
        drive(3'd0, 4'h0, 11'h080, 32'h0000_2000, 32'h0, 32'h0, 4'b0100, "R5");
        drive(3'd0, 4'h0, 11'h780, 32'h0000_2000, 32'h0, 32'h0, 4'b0100, "R5");
        drive(3'd0, 4'h1, 11'h0FF, 32'h0000_0000, 32'h0, 32'h0, 4'b0000, "R5");
        drive(3'd0, 4'h1, 11'h07F, 32'hFFFF_FF00, 32'h0, 32'h0, 4'b0000, "R5");

        // R6: unconditional, most negative, most positive
        drive(3'd1, 4'hE, 11'h400, 32'h0001_0000, 32'h0, 32'h0, 4'b0000, "R6");
        drive(3'd1, 4'h0, 11'h3FF, 32'h0001_0000, 32'h0, 32'h0, 4'b1111, "R6");

        // R7: first half, positive and negative high field
        drive(3'd2, 4'h0, 11'h001, 32'h0000_8000, 32'h0, 32'h0, 4'b0000, "R7");
        drive(3'd2, 4'h0, 11'h7FF, 32'h0000_8000, 32'h0, 32'h0, 4'b0000, "R7");
        drive(3'd2, 4'h0, 11'h400, 32'h0100_0000, 32'h0, 32'h0, 4'b0000, "R7");

        // R8: second half through the link value
        drive(3'd3, 4'h0, 11'h7FF, 32'h0000_8002, 32'h0, 32'h0000_7004, 4'b0000, "R8");
        drive(3'd3, 4'h0, 11'h000, 32'h0000_8010, 32'h0, 32'h1234_5678, 4'b0000, "R8");

        // R9: indirect, odd and even register values
        drive(3'd4, 4'h0, 11'h000, 32'h0000_0100, 32'h0000_4001, 32'h0, 4'b0000, "R9");
        drive(3'd4, 4'h0, 11'h000, 32'h0000_0100, 32'h0000_4000, 32'h0, 4'b0000, "R9");
        drive(3'd4, 4'h0, 11'h7FF, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0, 4'b1111, "R9");

        // R4: kind values outside the defined set
        drive(3'd5, 4'h0, 11'h010, 32'h0000_0100, 32'h0, 32'h0, 4'b0000, "R4");
        drive(3'd6, 4'h2, 11'h010, 32'h0000_0100, 32'h1, 32'h0, 4'b0010, "R4");
        drive(3'd7, 4'h4, 11'h010, 32'h0000_0100, 32'h0, 32'h0, 4'b1000, "R4");

        // R10: idle cycles produce nothing
        idle();
        idle();
        idle();
        @(posedge clk); #1;
        check(!out_valid && !taken && !lr_we && !state_clr && !undef,
              "R10", "idle outputs", {27'd0, out_valid, taken, lr_we, state_clr, undef}, 32'd0);
        check(sb.size() == 0, "R10", "pending results", 32'(sb.size()), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule